// File: doc/BRIEF.md
# Programmable-Format UART Transmitter with Rate Generator

This block turns bytes into asynchronous serial frames on a single output line. The frame format is chosen at run time: data length, parity style and stop period are all inputs. The bit rate is also an input, given as a plain integer in bits per second. The block works out its own timing from a fixed reference clock, which is 48 MHz by default.

When the format or the rate inputs change while the transmitter is idle, the block captures the new settings and checks them for legality. For a legal setting it then runs a shift-and-subtract divider that yields a rounded clock divider, and it applies a prescaler of 4 for very slow rates and 1 otherwise. During this calculation busy stays high. An illegal setting raises the error flag, and no byte is accepted until a legal setting is applied. Bytes arrive over a valid/ready handshake. Each accepted byte is sent as one complete frame, timed by half-bit ticks so that a stop period of one and a half bits comes out exact.

Top module: `fmtx_uart_tx`

## Requirements
- R1: While reset is asserted, tx_line is 1, busy is 0, cfg_err is 0 and in_ready is 0. After reset the block captures the settings, computes the divider and then raises in_ready.
- R2: A frame is a 0 start bit, then the data bits least significant first, with the count set by cfg_len (codes 0,1,2,3 give 5,6,7,8 bits). The line is 1 when idle.
- R3: cfg_parity code 0 adds no parity bit. Code 1 is even, code 2 is odd, code 3 is a constant 1 and code 4 is a constant 0. The parity bit follows the last data bit and covers only the data bits that are sent.
- R4: cfg_stop code 0 gives one stop bit, code 1 gives one and a half, and code 2 gives two. The line is 1 for the whole stop period.
- R5: The prescale P is 4 when the requested rate is at most 365 and 1 above that. Each bit lasts exactly 2·P·D reference cycles, where D is the divider.
- R6: D = floor((F_ref + P·rate) / (2·P·rate)). This rounds F_ref/(2·P·rate) to the nearest integer, with halves rounding up.
- R7: cfg_err is 1, in_ready is 0 and in_valid is ignored (the line stays 1 and busy stays 0) for any of these settings: rate below 300 or above 2,000,000; stop code 3; parity code above 4; one and a half stop bits with a data length other than 5; a 5- or 6-bit length above 921,600.
- R8: The settings are captured only while the block is idle, so a change made during a frame does not alter that frame. Once a legal change is captured, busy stays 1 and in_ready stays 0 until the divider is ready.
- R9: A byte is taken on a cycle where in_valid and in_ready are both 1. busy is 1 from the next cycle until the stop period ends. in_ready returns in the cycle where busy falls, unless the settings have changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_stop | input | 2 | Stop period code |
| cfg_parity | input | 3 | Parity style code |
| cfg_baud | input | 32 | Requested bit rate in bits per second |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress or divider being computed |
| cfg_err | output | 1 | Captured settings are illegal |

## Verification
Some properties are checked on every cycle by the assertions. A frame begins with a low line, and the line stays high through the stop period. The captured settings do not move while a frame is in progress. A new frame never starts with an erroneous setting, and the divider is never recomputed during a frame. A completed calculation always gives a non-zero half-bit length, and a taken byte always makes busy rise.

Other behaviour can only be shown by the bench's scenarios. These include the exact cycle-by-cycle line waveform for each format, and the measured bit length against the rounded formula, including rates where rounding and truncation differ and both sides of the prescale boundary. They also cover the rejection of each illegal combination, and a frame that is unaffected by a change of settings in mid-flight.

// File: rtl/txu_pkg.sv
package txu_pkg;
   localparam int unsigned BAUD_W  = 32;
   localparam int unsigned FRAME_W = 12;
   localparam int unsigned HALF_W  = 5;

   localparam logic [2:0] PAR_NONE  = 3'd0;
   localparam logic [2:0] PAR_EVEN  = 3'd1;
   localparam logic [2:0] PAR_ODD   = 3'd2;
   localparam logic [2:0] PAR_MARK  = 3'd3;
   localparam logic [2:0] PAR_SPACE = 3'd4;

   localparam logic [1:0] STP_ONE   = 2'd0;
   localparam logic [1:0] STP_HALF3 = 2'd1;
   localparam logic [1:0] STP_TWO   = 2'd2;

   typedef struct packed {
      logic [1:0]        len;
      logic [1:0]        stop;
      logic [2:0]        par;
      logic [BAUD_W-1:0] baud;
   } fmt_t;
endpackage

// File: rtl/txu_fmt_check.sv
module txu_fmt_check #(
   parameter int unsigned MIN_BAUD       = 300,
   parameter int unsigned MAX_BAUD       = 2_000_000,
   parameter int unsigned SHORT_MAX_BAUD = 921_600
) (
   input  txu_pkg::fmt_t fmt,
   output logic          bad
);
   logic rate_bad, stop_bad, par_bad, short_bad;

   always_comb begin
      rate_bad  = (fmt.baud < MIN_BAUD) || (fmt.baud > MAX_BAUD);
      stop_bad  = (fmt.stop == 2'd3) ||
                  ((fmt.stop == txu_pkg::STP_HALF3) && (fmt.len != 2'd0));
      par_bad   = fmt.par > txu_pkg::PAR_SPACE;
      short_bad = (fmt.len <= 2'd1) && (fmt.baud > SHORT_MAX_BAUD);
      bad       = rate_bad || stop_bad || par_bad || short_bad;
   end
endmodule

// File: rtl/txu_rate_div.sv
module txu_rate_div #(
   parameter int unsigned REF_HZ     = 48_000_000,
   parameter int unsigned PRESC_EDGE = 365,
   parameter int unsigned W          = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [txu_pkg::BAUD_W-1:0]   baud,
   output logic                         busy,
   output logic [W-1:0]                 half_len
);
   localparam int unsigned CNT_W = $clog2(W + 1);
   localparam logic [W-1:0] REF_V = W'(REF_HZ);

   logic             four_q, four_d, ge;
   logic [W-1:0]     num_q, den_q, quo_q, quo_nx, baud_w, scaled;
   logic [W:0]       rem_q, rem_sh, rem_nx;
   logic [CNT_W-1:0] left_q;

   always_comb begin
      baud_w = W'(baud);
      four_d = baud <= PRESC_EDGE;
      scaled = four_d ? (baud_w << 2) : baud_w;
      rem_sh = {rem_q[W-1:0], num_q[W-1]};
      ge     = rem_sh >= {1'b0, den_q};
      rem_nx = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo_nx = {quo_q[W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         four_q   <= 1'b0;
         num_q    <= '0;
         den_q    <= '0;
         rem_q    <= '0;
         quo_q    <= '0;
         left_q   <= '0;
         busy     <= 1'b0;
         half_len <= '0;
      end else if (start) begin
         four_q <= four_d;
         num_q  <= REF_V + scaled;
         den_q  <= scaled << 1;
         rem_q  <= '0;
         quo_q  <= '0;
         left_q <= CNT_W'(W);
         busy   <= 1'b1;
      end else if (busy) begin
         rem_q  <= rem_nx;
         quo_q  <= quo_nx;
         num_q  <= num_q << 1;
         left_q <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) begin
            busy     <= 1'b0;
            half_len <= four_q ? (quo_nx << 2) : quo_nx;
         end
      end
   end

   // R6: a finished calculation never leaves a zero-length half bit
   a_r6_half_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (half_len != '0));
endmodule

// File: rtl/txu_tick.sv
module txu_tick #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] half_len,
   output logic         tick
);
   logic [W-1:0] cnt_q;

   assign tick = (cnt_q == (half_len - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/txu_frame.sv
module txu_frame (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] data,
   input  logic [1:0] len,
   input  logic [1:0] stop,
   input  logic [2:0] par,
   input  logic       tick,
   output logic       active,
   output logic       tx
);
   import txu_pkg::*;

   logic [3:0]         nbits;
   logic [7:0]         kept;
   logic               par_en, par_bit;
   logic [2:0]         stop_h;
   logic [HALF_W-1:0]  halves;
   logic [FRAME_W-1:0] frame_d, sr_q;
   logic [HALF_W-1:0]  left_q;
   logic [2:0]         stoph_q;
   logic               phase_q;

   assign nbits = 4'd5 + {2'b00, len};

   // bits above the selected length are masked out of the parity sum
   for (genvar g = 0; g < 8; g++) begin : g_keep
      if (g < 5) begin : g_always
         assign kept[g] = data[g];
      end else begin : g_sized
         assign kept[g] = data[g] & (len >= 2'(g - 4));
      end
   end

   always_comb begin
      par_en = par != PAR_NONE;
      case (par)
         PAR_EVEN: par_bit = ^kept;
         PAR_ODD:  par_bit = ~^kept;
         PAR_MARK: par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
      case (stop)
         STP_HALF3: stop_h = 3'd3;
         STP_TWO:   stop_h = 3'd4;
         default:   stop_h = 3'd2;
      endcase
      frame_d    = '1;
      frame_d[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < int'(nbits)) frame_d[i+1] = data[i];
      if (par_en) frame_d[int'(nbits) + 1] = par_bit;
      halves = HALF_W'({nbits, 1'b0}) + HALF_W'(2) + HALF_W'({par_en, 1'b0}) + HALF_W'(stop_h);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '1;
         left_q  <= '0;
         stoph_q <= '0;
         phase_q <= 1'b0;
         active  <= 1'b0;
      end else if (load) begin
         sr_q    <= frame_d;
         left_q  <= halves;
         stoph_q <= stop_h;
         phase_q <= 1'b0;
         active  <= 1'b1;
      end else if (active && tick) begin
         left_q  <= left_q - 1'b1;
         phase_q <= ~phase_q;
         if (phase_q) sr_q <= {1'b1, sr_q[FRAME_W-1:1]};
         if (left_q == HALF_W'(1)) active <= 1'b0;
      end
   end

   assign tx = active ? sr_q[0] : 1'b1;

   // R2: every frame opens with a low start bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (tx == 1'b0));
   // R4: the line is high through the stop period
   a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (left_q <= HALF_W'(stoph_q))) |-> tx);
endmodule

// File: rtl/fmtx_uart_tx.sv
module fmtx_uart_tx #(
   parameter int unsigned REF_HZ         = 48_000_000,
   parameter int unsigned MIN_BAUD       = 300,
   parameter int unsigned MAX_BAUD       = 2_000_000,
   parameter int unsigned SHORT_MAX_BAUD = 921_600,
   parameter int unsigned PRESC_EDGE     = 365,
   parameter int unsigned CALC_W         = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cfg_len,
   input  logic [1:0]  cfg_stop,
   input  logic [2:0]  cfg_parity,
   input  logic [31:0] cfg_baud,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        tx_line,
   output logic        busy,
   output logic        cfg_err
);
   import txu_pkg::*;

   if (REF_HZ < MAX_BAUD) begin : g_bad_ref
      $error("reference clock too slow for the fastest rate");
   end
   if (CALC_W < BAUD_W) begin : g_bad_width
      $error("divider width narrower than the rate input");
   end
   if (MIN_BAUD > MAX_BAUD) begin : g_bad_range
      $error("rate range is empty");
   end

   fmt_t              in_fmt, fmt_q;
   logic              have_q, err_q, in_bad;
   logic              calc_busy, active, tick, idle, changed, latch, accept;
   logic [CALC_W-1:0] half_len;

   assign in_fmt = '{len: cfg_len, stop: cfg_stop, par: cfg_parity, baud: cfg_baud};

   txu_fmt_check #(
      .MIN_BAUD(MIN_BAUD), .MAX_BAUD(MAX_BAUD), .SHORT_MAX_BAUD(SHORT_MAX_BAUD)
   ) u_check (
      .fmt(in_fmt), .bad(in_bad)
   );

   assign idle    = !calc_busy && !active;
   assign changed = !have_q || (in_fmt != fmt_q);
   assign latch   = idle && changed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q  <= '0;
         have_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (latch) begin
         fmt_q  <= in_fmt;
         have_q <= 1'b1;
         err_q  <= in_bad;
      end
   end

   txu_rate_div #(
      .REF_HZ(REF_HZ), .PRESC_EDGE(PRESC_EDGE), .W(CALC_W)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .start(latch && !in_bad), .baud(cfg_baud),
      .busy(calc_busy), .half_len(half_len)
   );

   assign in_ready = idle && !changed && !err_q;
   assign accept   = in_valid && in_ready;

   txu_tick #(.W(CALC_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(accept), .half_len(half_len), .tick(tick)
   );

   txu_frame u_frame (
      .clk(clk), .rst_n(rst_n), .load(accept), .data(in_data),
      .len(fmt_q.len), .stop(fmt_q.stop), .par(fmt_q.par),
      .tick(tick), .active(active), .tx(tx_line)
   );

   assign busy    = calc_busy || active;
   assign cfg_err = err_q;

   // R8: captured settings hold still while a frame is on the line
   a_r8_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(fmt_q));
   // R8: the divider is never recomputed under a running frame
   a_r8_no_calc_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !calc_busy);
   // R7: no frame starts with an illegal setting captured
   a_r7_no_frame_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !err_q);
   // R9: a taken byte makes busy rise on the next cycle
   a_r9_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
endmodule

// File: tb/fmtx_uart_tx_test.sv
module fmtx_uart_tx_test;
   localparam int unsigned BENCH_REF = 2_400_000;
   localparam int unsigned WD_CYC    = 190_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_len = 2'd3;
   logic [1:0]  cfg_stop = 2'd0;
   logic [2:0]  cfg_parity = 3'd0;
   logic [31:0] cfg_baud = 32'd115200;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready, tx_line, busy, cfg_err;

   int n_chk = 0;
   int n_bad = 0;

   // values applied in the middle of a frame by the R8 scenario
   logic [1:0]  nx_len = 2'd2;
   logic [1:0]  nx_stop = 2'd2;
   logic [2:0]  nx_par = 3'd1;
   logic [31:0] nx_baud = 32'd400000;

   always #10 clk = ~clk;

   fmtx_uart_tx #(.REF_HZ(BENCH_REF)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_stop(cfg_stop),
      .cfg_parity(cfg_parity), .cfg_baud(cfg_baud), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line), .busy(busy),
      .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint exp_half(input longint baud);
      longint p, d;
      p = (baud <= 365) ? 4 : 1;
      d = (longint'(BENCH_REF) + p * baud) / (2 * p * baud);
      return p * d;
   endfunction

   task automatic apply_cfg(input int len, input int stp, input int par,
                            input int unsigned baud, input bit exp_err,
                            input string req);
      int n;
      @(negedge clk);
      cfg_len = 2'(len); cfg_stop = 2'(stp); cfg_parity = 3'(par); cfg_baud = baud;
      @(negedge clk);
      if (!exp_err) begin
         chk(busy == 1'b1, "R8", "busy during divider", busy, 1);
         chk(in_ready == 1'b0, "R8", "ready during divider", in_ready, 0);
      end
      n = 0;
      while (!(in_ready || cfg_err) && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(cfg_err == exp_err, req, "cfg_err", cfg_err, exp_err);
      chk(in_ready == !exp_err, req, "in_ready", in_ready, !exp_err);
   endtask

   task automatic send_frame(input logic [7:0] d, input int len, input int stp,
                             input int par, input int unsigned baud,
                             input string req, input bit mid);
      longint half, total;
      int n, ones, th, mism, bmism;
      logic [11:0] fb;
      logic pbit, e, first_act, first_exp;
      half = exp_half(baud);
      n = 5 + len;
      ones = $countones(d & (8'hFF >> (8 - n)));
      case (par)
         1: pbit = ones[0];
         2: pbit = ~ones[0];
         3: pbit = 1'b1;
         default: pbit = 1'b0;
      endcase
      fb = '1;
      fb[0] = 1'b0;
      for (int i = 0; i < n; i++) fb[i+1] = d[i];
      if (par != 0) fb[n+1] = pbit;
      th = 2 * (1 + n + ((par != 0) ? 1 : 0)) + ((stp == 1) ? 3 : (stp == 2) ? 4 : 2);
      total = longint'(th) * half;
      @(negedge clk);
      chk(in_ready == 1'b1, "R9", "ready before offer", in_ready, 1);
      in_valid = 1'b1;
      in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
      mism = 0; bmism = 0; first_act = 1'b0; first_exp = 1'b0;
      for (longint k = 0; k < total + 3; k++) begin
         e = (k < total) ? fb[k / (2 * half)] : 1'b1;
         if (tx_line !== e) begin
            if (mism == 0) begin first_act = tx_line; first_exp = e; end
            mism++;
         end
         if (k < total || k == total) begin
            if (busy !== (k < total)) bmism++;
         end else if (mid && busy !== 1'b1) bmism++;
         if (k == total)
            chk(in_ready == !mid, "R9", "ready when busy falls", in_ready, !mid);
         if (mid && k == 5) begin
            cfg_len = nx_len; cfg_stop = nx_stop; cfg_parity = nx_par; cfg_baud = nx_baud;
         end
         @(negedge clk);
      end
      chk(mism == 0, req, "line waveform", first_act, first_exp);
      chk(bmism == 0, req, "busy span (cycles wrong)", bmism, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_line == 1'b1, "R1", "tx in reset", tx_line, 1);
      chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
      chk(cfg_err == 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
      chk(in_ready == 1'b0, "R1", "ready in reset", in_ready, 0);
      rst_n = 1'b1;
      repeat (60) @(negedge clk);
      chk(in_ready == 1'b1, "R1", "ready after first divider", in_ready, 1);
   endtask

   task automatic t_formats();
      // R2 R4 R5: 8 data, no parity, one stop
      send_frame(8'hA5, 3, 0, 0, 115200, "R2", 1'b0);
      // R3 R4 R6: 5 data, even parity, 1.5 stop; rounding beats truncation
      apply_cfg(0, 1, 1, 57600, 1'b0, "R6");
      send_frame(8'h13, 0, 1, 1, 57600, "R3", 1'b0);
      // R3 R4 R6: 7 data, odd parity, two stop
      apply_cfg(2, 2, 2, 700000, 1'b0, "R6");
      send_frame(8'h5A, 2, 2, 2, 700000, "R3", 1'b0);
      // R3: constant-one parity at 6 bits, constant-zero parity at 8 bits
      apply_cfg(1, 0, 3, 400000, 1'b0, "R3");
      send_frame(8'hC2, 1, 0, 3, 400000, "R3", 1'b0);
      apply_cfg(3, 0, 4, 1000000, 1'b0, "R3");
      send_frame(8'hFF, 3, 0, 4, 1000000, "R3", 1'b0);
      // R3: even parity of all ones at 921600
      apply_cfg(3, 0, 1, 921600, 1'b0, "R3");
      send_frame(8'hFF, 3, 0, 1, 921600, "R3", 1'b0);
   endtask

   task automatic t_prescale();
      // R5: prescale 4 at 365, prescale 1 at 366
      apply_cfg(0, 0, 0, 365, 1'b0, "R5");
      send_frame(8'h0D, 0, 0, 0, 365, "R5", 1'b0);
      apply_cfg(0, 0, 0, 366, 1'b0, "R5");
      send_frame(8'h0D, 0, 0, 0, 366, "R5", 1'b0);
   endtask

   task automatic t_illegal();
      int txlow, bsy;
      apply_cfg(3, 0, 0, 299, 1'b1, "R7");
      apply_cfg(3, 0, 0, 2000001, 1'b1, "R7");
      apply_cfg(3, 1, 0, 115200, 1'b1, "R7");
      apply_cfg(0, 3, 0, 115200, 1'b1, "R7");
      apply_cfg(3, 0, 5, 115200, 1'b1, "R7");
      apply_cfg(1, 0, 0, 921601, 1'b1, "R7");
      // R7: offered bytes are ignored while the setting is illegal
      txlow = 0; bsy = 0;
      in_valid = 1'b1; in_data = 8'h00;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (tx_line !== 1'b1) txlow++;
         if (busy !== 1'b0) bsy++;
      end
      in_valid = 1'b0;
      chk(txlow == 0, "R7", "line left idle (low cycles)", txlow, 0);
      chk(bsy == 0, "R7", "busy stayed low (busy cycles)", bsy, 0);
      // edge values that are still legal
      apply_cfg(1, 0, 0, 921600, 1'b0, "R7");
      apply_cfg(3, 0, 0, 2000000, 1'b0, "R7");
      send_frame(8'h96, 3, 0, 0, 2000000, "R5", 1'b0);
   endtask

   task automatic t_midchange();
      // R8: settings changed in mid-frame do not touch the running frame
      apply_cfg(3, 0, 0, 115200, 1'b0, "R8");
      send_frame(8'h3C, 3, 0, 0, 115200, "R8", 1'b1);
      begin
         int n;
         n = 0;
         while (!in_ready && n < 200) begin
            @(negedge clk);
            n++;
         end
      end
      chk(in_ready == 1'b1, "R8", "ready after late change", in_ready, 1);
      send_frame(8'h6B, 2, 2, 1, 400000, "R8", 1'b0);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_formats();
      t_prescale();
      t_illegal();
      t_midchange();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule